// File: doc/BRIEF.md
# Descriptor Ring Bus-Master Engine

This block works through a ring of work descriptors held in host memory. Software programs the ring's base address and entry count, fills in descriptors, and marks each one as owned by the device. It then writes a tail index to the doorbell register. The engine compares its own head index against that tail. For each entry between them, it reads the four-word descriptor through its memory master port and either copies a run of words from one memory area to another or fills a receive buffer from an inbound word stream. It then writes the control word back with the ownership bit cleared and a status code, and advances the head index.

Events accumulate in a sticky interrupt status register and drive a single interrupt line. Three kinds of event are recorded: one descriptor finished, the ring drained, and an unrecognised operation. If the engine meets an entry that the host still owns, it stops without touching that entry. It waits for the next doorbell write before fetching again, so the host can hand entries over late without racing the engine.

Top module: `descring_engine`

## Requirements
- R1: After reset, irq is low, irq_status is 0, head_idx is 0 and mem_req is low.
- R2: A register write to address 2 (doorbell) loads the tail index from reg_wdata. The engine raises mem_req with mem_addr equal to the ring base on the second rising edge after the write edge. While head_idx equals the tail, no descriptor is fetched.
- R3: Entry i occupies four words starting at base + 4*i. Word 0 is control: bit 31 is the owner (1 = device) and bits 7:0 are the opcode. Word 1 is the buffer address, word 2 is the target address and word 3 is the length in words. Register address 0 holds the base and address 1 holds the entry count.
- R4: Opcode 0x01 (copy) moves `length` words from the buffer address upward to the target address upward.
- R5: Opcode 0x02 (receive) raises rx_ready once for each word. It stores `length` words, accepted when rx_valid and rx_ready are both high, into the buffer in arrival order. mem_req stays low while rx_ready is high.
- R6: On completion, control word 0 is rewritten with bit 31 cleared and a status code in bits 15:8 (0 = success, 1 = unknown opcode). All other bits are kept. head_idx then advances by one.
- R7: When word 0 of the head entry has owner 0, the engine writes nothing, keeps head_idx, and issues no further memory request until the next doorbell write, after which it refetches that entry.
- R8: Any opcode other than 0x01 or 0x02 gives status 1 with no data movement, and processing goes on to the next entry.
- R9: irq_status bit 0 sets when a descriptor is written back, bit 1 when head_idx reaches the tail, and bit 2 on an unknown-opcode completion. irq is high while any bit is set. Writing ones to register address 3 clears the matching bits, and irq goes low on that same edge.
- R10: Once mem_req is raised, it stays high with mem_addr and mem_we unchanged until the cycle in which mem_ack is seen.
- R11: head_idx wraps from count-1 to 0.
- R12: A descriptor with length 0 performs no data access and is only written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base, 1 count, 2 doorbell, 3 status clear |
| reg_wdata | input | DW | Register write data |
| irq | output | 1 | Interrupt, high while any status bit is set |
| irq_status | output | 3 | Sticky status: done, drained, error |
| head_idx | output | IW | Next entry the engine will process |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| rx_valid | input | 1 | Inbound word present |
| rx_data | input | DW | Inbound word |
| rx_ready | output | 1 | Engine accepts an inbound word |

## Verification
The doorbell is the only result with a fixed latency from a host write. mem_req must still be low one cycle after the write edge and must be high, pointing at the ring base, one cycle later. The bench samples exactly those two falling edges. Descriptor outcomes depend on memory acknowledge timing and on when inbound words arrive, so the bench polls irq or head_idx with a bounded wait. It then checks memory contents, the written-back control words and the status bits, all of which are settled by the edge that makes irq or head_idx change. The status clear takes effect on its write edge, so irq is checked at the next falling edge.

// File: rtl/descring_pkg.sv
package descring_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CTL, S_BUF, S_TGT, S_LEN,
    S_CPRD, S_CPWR, S_RXW, S_RXST, S_WB
  } seq_state_t;

  localparam logic [7:0] OPC_COPY  = 8'h01;
  localparam logic [7:0] OPC_RECV  = 8'h02;
  localparam logic [7:0] STS_OK    = 8'h00;
  localparam logic [7:0] STS_BADOP = 8'h01;
  localparam int         OWNER_BIT = 31;

  localparam logic [1:0] RA_BASE  = 2'd0;
  localparam logic [1:0] RA_COUNT = 2'd1;
  localparam logic [1:0] RA_BELL  = 2'd2;
  localparam logic [1:0] RA_CLEAR = 2'd3;
endpackage

// File: rtl/descring_regs.sv
module descring_regs import descring_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          ev_done,
  input  logic          ev_drain,
  input  logic          ev_err,
  output logic [AW-1:0] base,
  output logic [IW:0]   count,
  output logic [IW-1:0] tail,
  output logic          bell,
  output logic          irq,
  output logic [2:0]    irq_status
);
  logic [2:0] sts_next;
  logic       unused_wbits;
  assign unused_wbits = ^reg_wdata[DW-1:AW];

  always_comb begin
    sts_next = irq_status | {ev_err, ev_drain, ev_done};
    if (reg_wr && reg_addr == RA_CLEAR)
      sts_next = sts_next & ~reg_wdata[2:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base       <= '0;
      count      <= '0;
      tail       <= '0;
      bell       <= 1'b0;
      irq        <= 1'b0;
      irq_status <= '0;
    end else begin
      bell       <= reg_wr && reg_addr == RA_BELL;
      irq_status <= sts_next;
      irq        <= |sts_next;
      if (reg_wr) begin
        case (reg_addr)
          RA_BASE:  base  <= reg_wdata[AW-1:0];
          RA_COUNT: count <= reg_wdata[IW:0];
          RA_BELL:  tail  <= reg_wdata[IW-1:0];
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/descring_seq.sv
module descring_seq import descring_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base,
  input  logic [IW:0]   count,
  input  logic [IW-1:0] tail,
  input  logic          bell,
  output logic [IW-1:0] head,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          ev_done,
  output logic          ev_drain,
  output logic          ev_err
);
  seq_state_t    st;
  logic          parked;
  logic [DW-1:0] ctl, data_q;
  logic [AW-1:0] buf_a, tgt_a, len, cnt;
  logic [7:0]    status;
  logic [AW-1:0] slot;
  logic [IW:0]   inc;
  logic [IW-1:0] head_nx;
  logic          last;

  assign slot    = base + AW'({head, 2'b00});
  assign inc     = {1'b0, head} + 1'b1;
  assign head_nx = (inc == count) ? '0 : inc[IW-1:0];
  assign last    = (cnt + 1'b1) == len;
  assign rx_ready = (st == S_RXW);

  assign ev_done  = (st == S_WB) && mem_ack;
  assign ev_err   = ev_done && status == STS_BADOP;
  assign ev_drain = ev_done && head_nx == tail;

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = slot;
    mem_wdata = data_q;
    case (st)
      S_CTL:  mem_addr = slot;
      S_BUF:  mem_addr = slot + AW'(1);
      S_TGT:  mem_addr = slot + AW'(2);
      S_LEN:  mem_addr = slot + AW'(3);
      S_CPRD: mem_addr = buf_a + cnt;
      S_CPWR: begin mem_we = 1'b1; mem_addr = tgt_a + cnt; end
      S_RXST: begin mem_we = 1'b1; mem_addr = buf_a + cnt; end
      S_WB: begin
        mem_we    = 1'b1;
        mem_wdata = {1'b0, ctl[30:16], status, ctl[7:0]};
      end
      default: mem_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      parked <= 1'b0;
      head   <= '0;
      ctl    <= '0;
      data_q <= '0;
      buf_a  <= '0;
      tgt_a  <= '0;
      len    <= '0;
      cnt    <= '0;
      status <= STS_OK;
    end else begin
      case (st)
        S_IDLE: begin
          if (bell) parked <= 1'b0;
          if ((!parked || bell) && head != tail) st <= S_CTL;
        end
        S_CTL: if (mem_ack) begin
          ctl <= mem_rdata;
          if (!mem_rdata[OWNER_BIT]) begin
            parked <= 1'b1;
            st     <= S_IDLE;
          end else st <= S_BUF;
        end
        S_BUF: if (mem_ack) begin buf_a <= mem_rdata[AW-1:0]; st <= S_TGT; end
        S_TGT: if (mem_ack) begin tgt_a <= mem_rdata[AW-1:0]; st <= S_LEN; end
        S_LEN: if (mem_ack) begin
          len <= mem_rdata[AW-1:0];
          cnt <= '0;
          if (ctl[7:0] == OPC_COPY) begin
            status <= STS_OK;
            st <= (mem_rdata[AW-1:0] == '0) ? S_WB : S_CPRD;
          end else if (ctl[7:0] == OPC_RECV) begin
            status <= STS_OK;
            st <= (mem_rdata[AW-1:0] == '0) ? S_WB : S_RXW;
          end else begin
            status <= STS_BADOP;
            st <= S_WB;
          end
        end
        S_CPRD: if (mem_ack) begin data_q <= mem_rdata; st <= S_CPWR; end
        S_CPWR: if (mem_ack) begin
          cnt <= cnt + 1'b1;
          st  <= last ? S_WB : S_CPRD;
        end
        S_RXW: if (rx_valid) begin data_q <= rx_data; st <= S_RXST; end
        S_RXST: if (mem_ack) begin
          cnt <= cnt + 1'b1;
          st  <= last ? S_WB : S_RXW;
        end
        S_WB: if (mem_ack) begin
          head <= head_nx;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/descring_engine.sv
module descring_engine #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic          irq,
  output logic [2:0]    irq_status,
  output logic [IW-1:0] head_idx,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready
);
  logic [AW-1:0] base;
  logic [IW:0]   count;
  logic [IW-1:0] tail;
  logic          bell, ev_done, ev_drain, ev_err;

  descring_regs #(.AW(AW), .DW(DW), .IW(IW)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ev_done(ev_done), .ev_drain(ev_drain),
    .ev_err(ev_err), .base(base), .count(count), .tail(tail),
    .bell(bell), .irq(irq), .irq_status(irq_status)
  );

  descring_seq #(.AW(AW), .DW(DW), .IW(IW)) u_seq (
    .clk(clk), .rst(rst), .base(base), .count(count), .tail(tail),
    .bell(bell), .head(head_idx), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .ev_done(ev_done), .ev_drain(ev_drain),
    .ev_err(ev_err)
  );
endmodule

// File: rtl/descring_checker.sv
module descring_checker #(
  parameter int AW = 16,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          rx_ready,
  input logic [IW-1:0] head_idx,
  input logic [IW-1:0] tail,
  input logic [IW:0]   count,
  input logic [2:0]    irq_status
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_fetch_needs_work_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> head_idx != tail);

  p_head_wrap_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(head_idx) |->
      head_idx == ((({1'b0, $past(head_idx)} + 1'b1) == $past(count))
                   ? '0 : $past(head_idx) + 1'b1));

  p_done_after_write_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_status[0]) |-> $past(mem_req && mem_we && mem_ack));

  p_err_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_status[2]) |-> irq_status[0]);

  p_rx_no_bus_r5: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> !mem_req);
endmodule

bind descring_engine descring_checker #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .rx_ready(rx_ready),
  .head_idx(head_idx), .tail(tail), .count(count), .irq_status(irq_status)
);

// File: tb/descring_engine_bench.sv
module descring_engine_bench;
  localparam int AW = 16, DW = 32, IW = 4;
  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic irq, mem_req, mem_we, mem_ack, rx_ready;
  logic [2:0] irq_status;
  logic [IW-1:0] head_idx;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic rx_valid = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic [DW-1:0] mem [256];
  int n_chk = 0, n_bad = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  descring_engine #(.AW(AW), .DW(DW), .IW(IW)) u_descring_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq(irq), .irq_status(irq_status),
    .head_idx(head_idx), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready)
  );

  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[7:0]];
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 400 && !irq; i++) @(negedge clk);
  endtask

  task automatic wait_head(input logic [IW-1:0] h);
    for (int i = 0; i < 400 && head_idx != h; i++) @(negedge clk);
  endtask

  task automatic put_desc(input int slot, input logic [31:0] c, b, t, l);
    mem[8'h40 + 4*slot] = c; mem[8'h41 + 4*slot] = b;
    mem[8'h42 + 4*slot] = t; mem[8'h43 + 4*slot] = l;
  endtask

  task automatic t_reset();
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 status", {29'b0, irq_status}, 0);
    chk("R1 head", {28'b0, head_idx}, 0);
    chk("R1 req", {31'b0, mem_req}, 0);
  endtask

  task automatic t_copy();
    put_desc(0, 32'h80AB_0001, 32'h80, 32'h90, 3);
    mem[8'h80] = 32'h1111; mem[8'h81] = 32'h2222; mem[8'h82] = 32'h3333;
    reg_write(2'd0, 32'h40);
    reg_write(2'd1, 4);
    for (int i = 0; i < 5; i++) @(negedge clk);
    chk("R2 no fetch while empty", {31'b0, mem_req}, 0);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 1;
    @(negedge clk); reg_wr = 1'b0;
    chk("R2 req low one cycle after doorbell", {31'b0, mem_req}, 0);
    @(negedge clk);
    chk("R2 req high two cycles after doorbell", {31'b0, mem_req}, 1);
    chk("R3 first fetch at base", {16'b0, mem_addr}, 32'h40);
    wait_irq();
    chk("R4 copy word0", mem[8'h90], 32'h1111);
    chk("R4 copy word1", mem[8'h91], 32'h2222);
    chk("R4 copy word2", mem[8'h92], 32'h3333);
    chk("R6 writeback ok", mem[8'h40], 32'h00AB_0001);
    chk("R6 head advanced", {28'b0, head_idx}, 1);
    chk("R9 done and drained", {29'b0, irq_status}, 3);
    reg_write(2'd3, 7);
    chk("R9 irq cleared", {31'b0, irq}, 0);
    chk("R9 status cleared", {29'b0, irq_status}, 0);
  endtask

  task automatic t_recv();
    put_desc(1, 32'h8000_0002, 32'hA0, 32'h0, 2);
    reg_write(2'd2, 2);
    for (int w = 0; w < 2; w++) begin
      rx_valid = 1'b1; rx_data = 32'hCAFE_0001 + w;
      for (int i = 0; i < 100 && !rx_ready; i++) @(negedge clk);
      @(negedge clk); rx_valid = 1'b0;
    end
    wait_irq();
    chk("R5 rx word0", mem[8'hA0], 32'hCAFE_0001);
    chk("R5 rx word1", mem[8'hA1], 32'hCAFE_0002);
    chk("R6 recv writeback", mem[8'h44], 32'h0000_0002);
    chk("R9 status recv", {29'b0, irq_status}, 3);
    reg_write(2'd3, 7);
  endtask

  task automatic t_bad_zero_wrap();
    put_desc(2, 32'h8000_007F, 32'hB0, 32'hB4, 5);
    put_desc(3, 32'h8000_0001, 32'hB0, 32'hB8, 0);
    mem[8'hB4] = 32'h5555; mem[8'hB8] = 32'hDEAD;
    reg_write(2'd2, 0);
    wait_head(3);
    wait_head(0);
    @(negedge clk);
    chk("R8 bad opcode status", mem[8'h48], 32'h0000_017F);
    chk("R8 no data moved", mem[8'hB4], 32'h5555);
    chk("R12 zero length writeback", mem[8'h4C], 32'h0000_0001);
    chk("R12 target untouched", mem[8'hB8], 32'hDEAD);
    chk("R11 head wrapped", {28'b0, head_idx}, 0);
    chk("R9 R8 error bit", {29'b0, irq_status}, 7);
    reg_write(2'd3, 7);
  endtask

  task automatic t_park();
    int reqs;
    put_desc(0, 32'h0000_0001, 32'hC0, 32'hC8, 1);
    mem[8'hC0] = 32'h7777; mem[8'hC8] = 32'h0;
    reg_write(2'd2, 1);
    for (int i = 0; i < 12; i++) @(negedge clk);
    reqs = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (mem_req) reqs++; end
    chk("R7 idle after host-owned", reqs, 0);
    chk("R7 head held", {28'b0, head_idx}, 0);
    chk("R7 entry untouched", mem[8'h40], 32'h0000_0001);
    chk("R7 no irq", {31'b0, irq}, 0);
    mem[8'h40] = 32'h8000_0001;
    reg_write(2'd2, 1);
    wait_irq();
    chk("R7 processed after doorbell", mem[8'hC8], 32'h7777);
    chk("R7 head after doorbell", {28'b0, head_idx}, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_copy();
    t_recv();
    t_bad_zero_wrap();
    t_park();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule